// File: doc/BRIEF.md
# LED Driver Protection and Restart Sequencer

This block is the supervisory state machine of an offline LED lighting controller. It takes the digitised outputs of the analog comparators: the supply is above its undervoltage level, the supply has reached its overvoltage clamp, the primary current is above its overcurrent limit, the die is hot, the die has cooled, and the line sense is above 5 V. From these it decides whether the power stage may switch. It also decides when the startup clamp node is discharged, when the dimmer-detect output is forced to its default, and when the dimming set-point filter is held at zero, which gives minimum brightness.

Each fault has its own way back to normal operation. An overvoltage fault stops switching and discharges the clamp node until the supply drops below the undervoltage level, and then the controller restarts from off. A thermal fault does the same discharge, but it also waits for the cool flag before it restarts, and it keeps minimum brightness selected the whole time. An overcurrent fault only stops switching and forces minimum brightness. Switching resumes at the next low-to-high crossing of the line sense. All inputs pass through a synchroniser first, and the current state is shown on a 3-bit status code.

Top module: `led_fault_seq`

## Requirements
- R1: After reset the status code is 0 (off) and switching enable, clamp discharge, dimmer reset and filter reset are all low.
- R2: From off (code 0), a high supply-ok flag moves the block to standby (code 1), where all four control outputs stay low.
- R3: From standby, a high line-sense flag moves the block to run (code 2). Switching enable is high only in run.
- R4: An overvoltage flag in standby, run or overcurrent hold moves the block to overvoltage discharge (code 3). In that state switching enable is low, and clamp discharge and dimmer reset are high.
- R5: Overvoltage discharge holds while supply-ok stays high, even after the overvoltage flag clears. Loss of supply-ok returns the block to off.
- R6: An overcurrent flag in run moves the block to overcurrent hold (code 6). In that state switching enable is low and filter reset is high.
- R7: Overcurrent hold returns to run only on a low-to-high transition of line sense. A line sense that stays high does not release it.
- R8: A hot flag moves the block to thermal discharge (code 4), with clamp discharge and filter reset high. Loss of supply-ok then moves it to thermal wait (code 5), with filter reset high. Thermal wait holds until the cool flag is high, and then goes to off.
- R9: When faults arrive together, overvoltage takes priority over thermal, and thermal takes priority over overcurrent.
- R10: Every input flag passes through SYNC_STAGES flip-flops (default 2). A change takes effect in the state at the third rising edge after it.
- R11: Loss of supply-ok in standby, run or overcurrent hold, with no fault present, returns the block to off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok_a | input | 1 | Supply above the undervoltage threshold (asynchronous) |
| supply_ovp_a | input | 1 | Supply at the overvoltage clamp (asynchronous) |
| ocp_a | input | 1 | Primary current above the overcurrent limit (asynchronous) |
| temp_hot_a | input | 1 | Junction above the shutdown temperature (asynchronous) |
| temp_cool_a | input | 1 | Junction below the recovery temperature (asynchronous) |
| line_hi_a | input | 1 | Line sense above 5 V (asynchronous) |
| sw_en | output | 1 | Switching enable for the gate driver |
| clamp_dis | output | 1 | Discharge enable for the startup clamp node |
| dim_rst | output | 1 | Forces the dimmer-detect output to its default high state |
| filt_rst | output | 1 | Holds the set-point filter at zero (minimum brightness) |
| state_code | output | 3 | Encoded current state |

## Verification
The hardest case to reach from the ports is overcurrent hold with line sense already high. The block must wait for a fresh low-to-high edge and must not act on the level. The stimulus enters the fault while line sense is held high, keeps it high for several cycles, then drops it and raises it again. The status code is checked at each step. Fault priority is exercised by raising several fault flags in the same cycle, and the synchroniser latency is measured edge by edge from a single input change.

// File: rtl/led_fault_pkg.sv
package led_fault_pkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_STBY = 3'd1,
    ST_RUN  = 3'd2,
    ST_OVD  = 3'd3,
    ST_THD  = 3'd4,
    ST_THW  = 3'd5,
    ST_OCH  = 3'd6
  } seq_state_t;

  typedef struct packed {
    logic sw_en;
    logic clamp_dis;
    logic dim_rst;
    logic filt_rst;
  } seq_ctl_t;

  // Control outputs for each state
  function automatic seq_ctl_t ctl_of(input seq_state_t s);
    seq_ctl_t c;
    c = '0;
    case (s)
      ST_RUN: c.sw_en = 1'b1;
      ST_OVD: begin c.clamp_dis = 1'b1; c.dim_rst = 1'b1; end
      ST_THD: begin c.clamp_dis = 1'b1; c.filt_rst = 1'b1; end
      ST_THW: c.filt_rst = 1'b1;
      ST_OCH: c.filt_rst = 1'b1;
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_a,
  output logic [WIDTH-1:0] q_s
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d_a;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
    end
  end

  assign q_s = chain[STAGES-1];
endmodule

// File: rtl/fault_fsm.sv
module fault_fsm
  import led_fault_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sup_s,
  input  logic       ovp_s,
  input  logic       ocp_s,
  input  logic       hot_s,
  input  logic       cool_s,
  input  logic       line_s,
  output seq_state_t st
);
  seq_state_t st_n;
  logic       line_q;
  logic       line_rise;
  logic       active;

  assign line_rise = line_s & ~line_q;
  assign active    = (st == ST_STBY) || (st == ST_RUN) || (st == ST_OCH);

  always_comb begin
    st_n = st;
    case (st)
      ST_OFF: if (sup_s) st_n = ST_STBY;
      ST_STBY, ST_RUN, ST_OCH: begin
        if (ovp_s)       st_n = ST_OVD;
        else if (hot_s)  st_n = ST_THD;
        else if (!sup_s) st_n = ST_OFF;
        else if (st == ST_STBY && line_s)    st_n = ST_RUN;
        else if (st == ST_RUN && ocp_s)      st_n = ST_OCH;
        else if (st == ST_OCH && line_rise)  st_n = ST_RUN;
      end
      ST_OVD: if (!sup_s)  st_n = ST_OFF;
      ST_THD: if (!sup_s)  st_n = ST_THW;
      ST_THW: if (cool_s)  st_n = ST_OFF;
      default: st_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= ST_OFF;
      line_q <= 1'b0;
    end else begin
      st     <= st_n;
      line_q <= line_s;
    end

  assert_ovp_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && ovp_s) |=> (st == ST_OVD));
  assert_thermal_over_ocp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hot_s && !ovp_s) |=> (st == ST_THD));
  assert_ovd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OVD && sup_s) |=> (st == ST_OVD));
  assert_och_no_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OCH && sup_s && !ovp_s && !hot_s && !line_rise) |=> (st == ST_OCH));
  assert_thw_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_THW && !cool_s) |=> (st == ST_THW));
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
  import led_fault_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_t st,
  output logic       sw_en,
  output logic       clamp_dis,
  output logic       dim_rst,
  output logic       filt_rst,
  output logic [2:0] state_code
);
  seq_ctl_t c;
  assign c          = ctl_of(st);
  assign sw_en      = c.sw_en;
  assign clamp_dis  = c.clamp_dis;
  assign dim_rst    = c.dim_rst;
  assign filt_rst   = c.filt_rst;
  assign state_code = st;

  assert_run_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_en) |-> $past(state_code) inside {3'd1, 3'd6});
endmodule

// File: rtl/led_fault_seq.sv
module led_fault_seq
  import led_fault_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok_a,
  input  logic       supply_ovp_a,
  input  logic       ocp_a,
  input  logic       temp_hot_a,
  input  logic       temp_cool_a,
  input  logic       line_hi_a,
  output logic       sw_en,
  output logic       clamp_dis,
  output logic       dim_rst,
  output logic       filt_rst,
  output logic [2:0] state_code
);
  localparam int NFLAG = 6;

  logic [NFLAG-1:0] raw_a, flg_s;
  seq_state_t       st;

  assign raw_a = {supply_ok_a, supply_ovp_a, ocp_a, temp_hot_a, temp_cool_a, line_hi_a};

  flag_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_a(raw_a), .q_s(flg_s));

  fault_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .sup_s(flg_s[5]), .ovp_s(flg_s[4]), .ocp_s(flg_s[3]),
    .hot_s(flg_s[2]), .cool_s(flg_s[1]), .line_s(flg_s[0]),
    .st(st));

  ctl_decode u_dec (
    .clk(clk), .rst_n(rst_n), .st(st),
    .sw_en(sw_en), .clamp_dis(clamp_dis), .dim_rst(dim_rst),
    .filt_rst(filt_rst), .state_code(state_code));
endmodule

// File: tb/sim_led_fault_seq.sv
module sim_led_fault_seq;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 6;
  localparam int NVEC = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sup = 0, ovp = 0, ocp = 0, hot = 0, cool = 0, line = 0;
  logic sw_en, clamp_dis, dim_rst, filt_rst;
  logic [2:0] state_code;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  led_fault_seq u0 (
    .clk(clk), .rst_n(rst_n), .supply_ok_a(sup), .supply_ovp_a(ovp),
    .ocp_a(ocp), .temp_hot_a(hot), .temp_cool_a(cool), .line_hi_a(line),
    .sw_en(sw_en), .clamp_dis(clamp_dis), .dim_rst(dim_rst),
    .filt_rst(filt_rst), .state_code(state_code));

  // {sup,ovp,ocp,hot,cool,line} , state , {sw,clamp,dimrst,filt}
  localparam logic [12:0] TBL [NVEC] = '{
    {6'b100000, 3'd1, 4'b0000},  // R2 standby
    {6'b100001, 3'd2, 4'b1000},  // R3 run
    {6'b101001, 3'd6, 4'b0001},  // R6 overcurrent hold
    {6'b100001, 3'd6, 4'b0001},  // R7 line held high
    {6'b100000, 3'd6, 4'b0001},  // R7 line low
    {6'b100001, 3'd2, 4'b1000},  // R7 rising edge resumes
    {6'b110001, 3'd3, 4'b0110},  // R4 overvoltage
    {6'b100001, 3'd3, 4'b0110},  // R5 hold while supply ok
    {6'b000000, 3'd0, 4'b0000},  // R5 supply loss -> off
    {6'b100001, 3'd2, 4'b1000},  // R2 R3 restart
    {6'b100101, 3'd4, 4'b0101},  // R8 thermal discharge
    {6'b100001, 3'd4, 4'b0101},  // R8 hold
    {6'b000001, 3'd5, 4'b0001},  // R8 thermal wait
    {6'b100000, 3'd5, 4'b0001},  // R8 still hot
    {6'b100010, 3'd1, 4'b0000},  // R8 cooled -> off -> standby
    {6'b100001, 3'd2, 4'b1000},  // R3 run
    {6'b111101, 3'd3, 4'b0110},  // R9 ovp wins
    {6'b000000, 3'd0, 4'b0000},  // R5 off
    {6'b100001, 3'd2, 4'b1000},  // R3 run
    {6'b101101, 3'd4, 4'b0101},  // R9 thermal beats ocp
    {6'b000000, 3'd5, 4'b0001},  // R8 wait
    {6'b000010, 3'd0, 4'b0000},  // R8 cooled, no supply
    {6'b100000, 3'd1, 4'b0000},  // R2 standby
    {6'b000000, 3'd0, 4'b0000}   // R11 supply loss
  };

  task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got state=%0d ctl=%b expected state=%0d ctl=%b",
               req, act[6:4], act[3:0], exp[6:4], exp[3:0]);
    end
  endtask

  function automatic logic [6:0] obs();
    return {state_code, sw_en, clamp_dis, dim_rst, filt_rst};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", obs(), 7'b000_0000);
    rst_n = 1'b1;
    // R10 latency: change lands on the third rising edge
    @(negedge clk); sup = 1;
    repeat (2) @(posedge clk);
    @(negedge clk); chk("R10 before", obs(), 7'b000_0000);
    @(negedge clk); chk("R10 after", obs(), 7'b001_0000);
    for (int i = 0; i < NVEC; i++) begin
      {sup, ovp, ocp, hot, cool, line} = TBL[i][12:7];
      repeat (SETTLE) @(negedge clk);
      chk($sformatf("vec%0d R2-table", i), obs(), TBL[i][6:0]);
    end
    // R11 from run
    sup = 1; line = 1;
    repeat (SETTLE) @(negedge clk);
    chk("R3", obs(), 7'b010_1000);
    sup = 0;
    repeat (SETTLE) @(negedge clk);
    chk("R11", obs(), 7'b000_0000);
    // R1 reset mid-run
    sup = 1;
    repeat (SETTLE) @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1 async", obs(), 7'b000_0000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule